// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits beside an SDRAM command sequencer. It holds a mode word and turns each read or write command into a sequence of column addresses, one per clock. Software-visible mode loads come in as a 13-bit address-bus value on a load strobe. The block keeps the burst length, the ordering, the CAS latency and the write policy from that value, and rejects any value that uses a reserved code.

A start strobe gives a starting column and a read/write flag. The block then emits beats marked with a valid flag and marks the final one with a last flag. A fixed burst of length L stays inside the L-aligned group of columns that contains the start column, and wraps within it. The order is either "add and wrap" or "XOR with the beat index". A full-page burst walks the whole page, wrapping at the top, until a terminate input ends it. Beat counting always starts at 0 for the first column emitted.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_valid is 0, mode_err is 0 and cas_lat reads 2. The stored mode is length 1, add-and-wrap order, single-location-write mode off.
- R2: Mode bits [2:0] select the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page, which ends only on terminate.
- R3: With bit 3 at 0, beat i of a fixed burst of length L is column (start − start mod L) + ((start mod L + i) mod L). All beats of a burst share the column bits above log2(L).
- R4: With bit 3 at 1, beat i of a fixed burst of length L is column (start − start mod L) + ((start mod L) XOR i).
- R5: In full-page mode, beat i is column (start + i) mod 2^COL_W. col_last is raised only in the cycle in which terminate is high.
- R6: terminate high during a fixed-length burst makes that beat the last one.
- R7: col_last marks beat L−1 of a fixed burst. col_valid is 0 in the next cycle. A start in that next cycle is accepted. A start during a burst has no effect on it.
- R8: With bit 9 at 1, a write produces one beat, at the start column, with col_last set. A read still uses the programmed length.
- R9: Mode bits [6:4] give the CAS latency: 010 gives 2 and 011 gives 3. The value is reported on cas_lat.
- R10: A load is rejected if it carries any of the following: a length code other than 000, 001, 010, 011 or 111; length 111 together with bit 3 at 1; a latency code other than 010 or 011; bits [8:7] not 00; bits [11:10] not 00; bit 12 at 1. A rejected load sets the sticky mode_err and leaves the stored mode unchanged.
- R11: A load while a burst is running is ignored. It sets mode_err, and the running burst and later bursts keep the old mode.
- R12: The first beat appears in the cycle after the clock edge that samples start, and beats follow one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load strobe for the mode word |
| mode_word | input | 13 | Mode value from the address bus |
| start | input | 1 | Starts a burst when the block is idle |
| start_col | input | COL_W | Starting column |
| is_write | input | 1 | 1 for a write command, 0 for a read command |
| terminate | input | 1 | Ends the current burst on this beat |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is present |
| col_last | output | 1 | The present beat is the final beat |
| cas_lat | output | 2 | Programmed CAS latency (2 or 3) |
| mode_err | output | 1 | Sticky flag for rejected or ignored loads |

## Verification
Bursts are run from start columns at the bottom, the middle and the top of their aligned groups, so that a wrap to the group start can be told apart from a carry into the next group. The same start column is run in add-and-wrap order and in XOR order, which separates the two orderings. A full-page burst that starts two columns below the top of the page shows wrapping across the page boundary, and early terminates on both burst kinds show where col_last falls. Each reserved code is loaded after a known-good mode, and a burst run afterwards shows whether the old length and latency survived.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int MODE_W = 13;

  typedef struct packed {
    logic [2:0] len_code;
    logic       interleave;
    logic       cas_three;
    logic       wr_single;
  } mode_t;

  localparam mode_t MODE_RESET = '{len_code: 3'b000, interleave: 1'b0,
                                   cas_three: 1'b0, wr_single: 1'b0};

  function automatic logic is_full_code(input logic [2:0] code);
    return code == 3'b111;
  endfunction

  // log2 of the fixed burst length; full page handled separately
  function automatic logic [1:0] len_log2(input logic [2:0] code);
    return code[1:0];
  endfunction

  function automatic logic word_reserved(input logic [MODE_W-1:0] w);
    logic bad_len, bad_mix, bad_cas, bad_op, bad_top;
    bad_len = (w[2] == 1'b1) && (w[1:0] != 2'b11);
    bad_mix = (w[2:0] == 3'b111) && w[3];
    bad_cas = (w[6:4] != 3'b010) && (w[6:4] != 3'b011);
    bad_op  = w[8:7] != 2'b00;
    bad_top = w[12:10] != 3'b000;
    return bad_len | bad_mix | bad_cas | bad_op | bad_top;
  endfunction

  function automatic mode_t word_decode(input logic [MODE_W-1:0] w);
    mode_t m;
    m.len_code   = w[2:0];
    m.interleave = w[3];
    m.cas_three  = w[4];
    m.wr_single  = w[9];
    return m;
  endfunction
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_col_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  input  logic              busy,
  output mode_t             mode,
  output logic              err,
  output logic              load_bad,
  output logic              load_ignored
);
  logic load_ok;

  assign load_ignored = load && busy;
  assign load_bad     = load && !busy && word_reserved(word);
  assign load_ok      = load && !busy && !word_reserved(word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_RESET;
      err  <= 1'b0;
    end else begin
      if (load_ok) mode <= word_decode(word);
      if (load_bad || load_ignored) err <= 1'b1;
    end
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             is_write,
  input  logic             terminate,
  input  mode_t            mode,
  output logic             busy,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output logic [1:0]       cur_lg,
  output logic             cur_full,
  output logic             cur_inter,
  output logic             last_beat
);
  logic             accept;
  logic             force_single;
  logic [COL_W-1:0] final_idx;

  assign accept       = start && !busy;
  assign force_single = is_write && mode.wr_single;
  assign final_idx    = (COL_W'(1) << cur_lg) - COL_W'(1);
  assign last_beat    = busy && (terminate || (!cur_full && (beat == final_idx)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      base      <= '0;
      beat      <= '0;
      cur_lg    <= '0;
      cur_full  <= 1'b0;
      cur_inter <= 1'b0;
    end else if (accept) begin
      busy      <= 1'b1;
      base      <= start_col;
      beat      <= '0;
      cur_inter <= mode.interleave;
      cur_lg    <= force_single ? 2'd0 : len_log2(mode.len_code);
      cur_full  <= force_single ? 1'b0 : is_full_code(mode.len_code);
    end else if (busy) begin
      if (last_beat) busy <= 1'b0;
      else           beat <= beat + COL_W'(1);
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [12:0]      mode_word,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             is_write,
  input  logic             terminate,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic [1:0]       cas_lat,
  output logic             mode_err
);
  mode_t            mode;
  logic             busy;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] beat;
  logic [1:0]       cur_lg;
  logic             cur_full;
  logic             cur_inter;
  logic             last_beat;
  logic             load_bad;
  logic             load_ignored;

  // Column of beat n: the low lg bits move, the bits above stay put
  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] n,
    input logic [1:0] lg, input logic inter, input logic full);
    logic [COL_W-1:0] mask, low;
    mask = (COL_W'(1) << lg) - COL_W'(1);
    low  = inter ? (b ^ n) : (b + n);
    if (full) return b + n;
    return (b & ~mask) | (low & mask);
  endfunction

  burst_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .word(mode_word),
    .busy(busy), .mode(mode), .err(mode_err),
    .load_bad(load_bad), .load_ignored(load_ignored)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .is_write(is_write), .terminate(terminate), .mode(mode),
    .busy(busy), .base(base), .beat(beat), .cur_lg(cur_lg),
    .cur_full(cur_full), .cur_inter(cur_inter), .last_beat(last_beat)
  );

  assign col_valid = busy;
  assign col_last  = last_beat;
  assign col_out   = beat_col(base, beat, cur_lg, cur_inter, cur_full);
  assign cas_lat   = {1'b1, mode.cas_three};
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             mode_load,
  input logic             col_valid,
  input logic             col_last,
  input logic [COL_W-1:0] col_out,
  input logic             mode_err,
  input logic [1:0]       cur_lg,
  input logic             cur_full
);
  p_first_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !col_valid) |=> col_valid);

  p_idle_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |=> !col_valid);

  p_no_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last) |=> col_valid);

  p_stay_in_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !cur_full) |=>
      ((col_out >> cur_lg) == ($past(col_out) >> cur_lg)));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);

  p_busy_load_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && col_valid) |=> mode_err);
endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode_load(mode_load),
  .col_valid(col_valid), .col_last(col_last), .col_out(col_out),
  .mode_err(mode_err), .cur_lg(cur_lg), .cur_full(cur_full)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_load = 1'b0;
  logic [12:0]      mode_word = '0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             is_write = 1'b0;
  logic             terminate = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             col_last;
  logic [1:0]       cas_lat;
  logic             mode_err;

  int checks = 0;
  int fails  = 0;
  int q_col[$];
  bit q_last[$];
  string q_tag[$];

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every beat
  always begin
    @(negedge clk);
    #1;
    if (rst_n && col_valid) begin
      if (q_col.size() == 0) begin
        check(1'b0, "R7 unexpected beat", int'(col_out), -1);
      end else begin
        int ec;
        bit el;
        string et;
        ec = q_col.pop_front();
        el = q_last.pop_front();
        et = q_tag.pop_front();
        check(int'(col_out) == ec && col_last == el, et,
              int'(col_out) * 2 + int'(col_last), ec * 2 + int'(el));
      end
    end
  end

  function automatic logic [12:0] mk(input int len, input int bt, input int cas,
                                     input int op, input int wb, input int top);
    logic [12:0] w;
    w = {top[2:0], wb[0], op[1:0], cas[2:0], bt[0], len[2:0]};
    return w;
  endfunction

  // expected beats; len 0 means full page
  task automatic expect_burst(input int col, input int len, input bit inter,
                              input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int e;
      if (len == 0) e = (col + i) % PAGE;
      else begin
        int off;
        off = col % len;
        e = (col - off) + (inter ? (off ^ i) : ((off + i) % len));
      end
      q_col.push_back(e);
      q_last.push_back(i == n - 1);
      q_tag.push_back(tag);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input logic [12:0] w);
    mode_load = 1'b1;
    mode_word = w;
    @(posedge clk);
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  // driver: called at a falling edge, leaves at a falling edge
  task automatic burst(input int col, input bit wr, input int len, input bit inter,
                       input int n, input int term_at, input int poke_at,
                       input int load_at, input logic [12:0] lw, input string tag);
    expect_burst(col, len, inter, n, tag);
    start = 1'b1;
    start_col = col[COL_W-1:0];
    is_write = wr;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      terminate = (i == term_at);
      start = (i == poke_at);
      if (i == poke_at) start_col = col[COL_W-1:0] ^ 9'd1;
      mode_load = (i == load_at);
      mode_word = lw;
      @(posedge clk);
      @(negedge clk);
    end
    terminate = 1'b0;
    start = 1'b0;
    mode_load = 1'b0;
    #2;
    check(q_col.size() == 0, {tag, " beats missing"}, q_col.size(), 0);
    check(!col_valid, "R7 idle after last", int'(col_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    #2;
    check(!col_valid, "R1 valid at reset", int'(col_valid), 0);
    check(!mode_err, "R1 err at reset", int'(mode_err), 0);
    check(cas_lat == 2'd2, "R1 cas at reset", int'(cas_lat), 2);
    @(negedge clk);
    burst(5, 0, 1, 0, 1, -1, -1, -1, '0, "R2 default length 1");

    load(mk(3'b010, 0, 3'b011, 0, 0, 0));
    check(cas_lat == 2'd3, "R9 cas 3", int'(cas_lat), 3);
    check(!mode_err, "R10 good load no err", int'(mode_err), 0);
    burst(6, 0, 4, 0, 4, -1, -1, -1, '0, "R3 seq len4 wrap");
    burst(8, 0, 4, 0, 4, -1, -1, -1, '0, "R12 back-to-back");

    load(mk(3'b011, 0, 3'b010, 0, 0, 0));
    check(cas_lat == 2'd2, "R9 cas 2", int'(cas_lat), 2);
    burst(13, 1, 8, 0, 8, -1, 3, -1, '0, "R7 seq len8 start poke");
    burst(40, 0, 8, 0, 3, 2, -1, -1, '0, "R6 terminate fixed");

    load(mk(3'b001, 0, 3'b010, 0, 0, 0));
    burst(3, 0, 2, 0, 2, -1, -1, -1, '0, "R2 seq len2");

    load(mk(3'b011, 1, 3'b010, 0, 0, 0));
    burst(5, 0, 8, 1, 8, -1, -1, -1, '0, "R4 xor len8");
    load(mk(3'b010, 1, 3'b010, 0, 0, 0));
    burst(30, 0, 4, 1, 4, -1, -1, -1, '0, "R4 xor len4");

    load(mk(3'b111, 0, 3'b011, 0, 0, 0));
    burst(510, 0, 0, 0, 5, 4, -1, -1, '0, "R5 full page wrap");
    burst(100, 0, 0, 0, 20, 19, -1, -1, '0, "R5 full page long");

    load(mk(3'b010, 0, 3'b010, 0, 1, 0));
    burst(9, 1, 1, 0, 1, -1, -1, -1, '0, "R8 single write");
    burst(9, 0, 4, 0, 4, -1, -1, -1, '0, "R8 read keeps length");

    load(mk(3'b011, 0, 3'b011, 0, 0, 0));
    check(!mode_err, "R10 no err before", int'(mode_err), 0);
    load(mk(3'b100, 0, 3'b010, 0, 0, 0));
    check(mode_err, "R10 bad length flags", int'(mode_err), 1);
    check(cas_lat == 2'd3, "R10 cas kept", int'(cas_lat), 3);
    load(mk(3'b111, 1, 3'b011, 0, 0, 0));
    load(mk(3'b001, 0, 3'b001, 0, 0, 0));
    load(mk(3'b001, 0, 3'b011, 1, 0, 0));
    load(mk(3'b001, 0, 3'b011, 0, 0, 1));
    load(mk(3'b001, 0, 3'b011, 0, 0, 4));
    check(cas_lat == 2'd3, "R10 cas kept after all", int'(cas_lat), 3);
    burst(2, 0, 8, 0, 8, -1, -1, -1, '0, "R10 length kept");

    do_reset();
    #2;
    check(!mode_err, "R1 err cleared", int'(mode_err), 0);
    @(negedge clk);
    load(mk(3'b010, 0, 3'b010, 0, 0, 0));
    burst(20, 0, 4, 0, 4, -1, 2, 1, mk(3'b001, 0, 3'b010, 0, 0, 0), "R11 load mid burst");
    check(mode_err, "R11 err set", int'(mode_err), 1);
    burst(21, 0, 4, 0, 4, -1, -1, -1, '0, "R11 mode kept");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule